// File: doc/BRIEF.md
# Converter Serial Output Sequencer

This block is the device-side control logic of a 12-bit sampling converter that talks over a three-wire serial port. The port has an active-low chip select, a shift clock from the host, and a data output that can be released to high impedance. A fast system clock samples both port inputs, and the block detects their edges from the synchronised values. The 12-bit result comes from an abstract converter model on a parallel input, and the block latches it when a frame opens. It then shifts a 16-bit frame out, one bit per falling shift-clock edge.

Alongside the serial data the block drives the sample/hold control, a conversion-busy flag and a data-valid flag, and it tracks whether the converter is powered or asleep. Where the host releases chip select inside a frame decides what comes next. An early release puts the converter to sleep. A late release cancels the conversion but keeps power. A frame that starts from sleep is a dummy wake-up frame: its data is marked invalid, and it powers the converter up once it completes.

Top module: `adc_serial_port`

## Requirements
- R1: When chip select falls, hold goes to 1, busy goes to 1 and the output enable goes to 1, with the data output at 0 (first leading zero).
- R2: A complete frame is 16 bits: two zeros, the 12 sample bits most significant first, then two zeros. After the k-th falling shift-clock edge (k = 1..15) the output shows frame bit 15-k, where bit 15 is the first zero sent.
- R3: The data output changes only in response to a chip-select fall or a falling shift-clock edge.
- R4: In a powered frame, busy drops at the 13th falling edge and hold drops at the 14th.
- R5: The output enable drops at the 16th falling edge, further falling edges are ignored, and the enable is 0 whenever chip select is high.
- R6: After reset the block is asleep (powered = 0), with hold = 1, busy = 0, output enable = 0 and data_valid = 0.
- R7: If chip select rises in a powered frame after 2 to 9 falling edges, the block enters sleep (powered = 0, hold = 1).
- R8: If chip select rises in a powered frame after 10 to 15 falling edges, the block stays powered, and busy, hold and output enable all go to 0.
- R9: A frame that starts from sleep has data_valid = 0 and releases hold after its 1st falling edge. It sets powered after its 16th falling edge. If chip select is released before that edge, the block stays asleep with hold = 1.
- R10: The sample word is captured when chip select falls. Later changes on the sample input do not affect the frame being shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the shift clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csn_pad | input | 1 | Chip select from the host, active low, asynchronous |
| sck_pad | input | 1 | Shift clock from the host, asynchronous |
| sample_in | input | 12 | Result word from the converter model |
| sdo | output | 1 | Serial data output |
| sdo_oe | output | 1 | Output enable for sdo; 0 means high impedance |
| hold | output | 1 | Sample/hold control, 1 = hold |
| busy | output | 1 | Conversion in progress |
| powered | output | 1 | 1 = operating, 0 = sleep |
| data_valid | output | 1 | Current frame started while powered |

## Verification
The shifted data is tried with a stride sweep over the code range, with walking single ones that expose any bit-position slip, and with the alternating and all-ones words that expose any swap between neighbouring bits. During every frame the sample input is inverted, so a capture taken at the wrong time shows up as miscompared bits. Chip-select release is tried at edge counts 2, 5, 9, 10 and 12 to separate the sleep window from the abort window at both of its boundaries. Wake-up frames are run both cut short and complete, which tells a stay-asleep result apart from a power-up.

// File: rtl/adc_serial_port.sv
module adc_serial_port #(
  parameter int RES  = 12,
  parameter int LEAD = 2,
  parameter int TAIL = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           csn_pad,
  input  logic           sck_pad,
  input  logic [RES-1:0] sample_in,
  output logic           sdo,
  output logic           sdo_oe,
  output logic           hold,
  output logic           busy,
  output logic           powered,
  output logic           data_valid
);
  localparam int FRAME   = LEAD + RES + TAIL;
  localparam int CW      = $clog2(FRAME + 1);
  localparam int DONE_AT = LEAD + RES - 1;
  localparam int SAMP_AT = LEAD + RES;
  localparam int SLP_LO  = 2;
  localparam int SLP_HI  = 10;

  logic [2:0]       cs_sy, sck_sy;
  logic [CW-1:0]    cnt;
  logic [FRAME-1:0] sh;
  logic             active, wake;

  wire cs_fall  = cs_sy[2] & ~cs_sy[1];
  wire cs_rise  = ~cs_sy[2] & cs_sy[1];
  wire sck_edge = sck_sy[2] & ~sck_sy[1];
  wire sck_fall = sck_edge & active & ~cs_sy[1] & (cnt < CW'(FRAME));
  wire [CW-1:0] nxt = cnt + 1'b1;

  assign sdo = sh[FRAME-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sy  <= '1;
      sck_sy <= '0;
    end else begin
      cs_sy  <= {cs_sy[1:0], csn_pad};
      sck_sy <= {sck_sy[1:0], sck_pad};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      sh         <= '0;
      active     <= 1'b0;
      wake       <= 1'b0;
      sdo_oe     <= 1'b0;
      hold       <= 1'b1;
      busy       <= 1'b0;
      powered    <= 1'b0;
      data_valid <= 1'b0;
    end else if (cs_fall) begin
      active     <= 1'b1;
      cnt        <= '0;
      sh         <= {{LEAD{1'b0}}, sample_in, {TAIL{1'b0}}};
      sdo_oe     <= 1'b1;
      hold       <= 1'b1;
      busy       <= 1'b1;
      data_valid <= powered;
      wake       <= ~powered;
    end else if (cs_rise) begin
      active <= 1'b0;
      sdo_oe <= 1'b0;
      busy   <= 1'b0;
      if (active) begin
        if (wake) begin
          hold <= 1'b1;
          wake <= 1'b0;
        end else if (cnt >= CW'(SLP_LO) && cnt < CW'(SLP_HI)) begin
          powered <= 1'b0;
          hold    <= 1'b1;
        end else begin
          hold <= 1'b0;
        end
      end
    end else if (sck_fall) begin
      cnt <= nxt;
      sh  <= sh << 1;
      if (nxt == CW'(FRAME))   sdo_oe <= 1'b0;
      if (nxt == CW'(DONE_AT)) busy   <= 1'b0;
      if (!wake && nxt == CW'(SAMP_AT)) hold <= 1'b0;
      if (wake && nxt == CW'(1))        hold <= 1'b0;
      if (wake && nxt == CW'(FRAME)) begin
        powered <= 1'b1;
        wake    <= 1'b0;
      end
    end
  end

  AST_OE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_sy[1] && cs_sy[2]) |-> !sdo_oe); // R5
  AST_SDO_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!sck_edge && !cs_fall) |=> $stable(sdo)); // R3
  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(FRAME)); // R2
  AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!powered && !active) |-> hold); // R7
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && data_valid) |-> hold); // R4
  AST_WAKE_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(powered) |-> !data_valid); // R9
endmodule

// File: tb/adc_serial_port_tb_top.sv
module adc_serial_port_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, csn = 1'b1, sck = 1'b0;
  logic [11:0] smp = '0;
  logic sdo, sdo_oe, hold, busy, powered, data_valid;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  adc_serial_port dut_i (
    .clk(clk), .rst_n(rst_n), .csn_pad(csn), .sck_pad(sck), .sample_in(smp),
    .sdo(sdo), .sdo_oe(sdo_oe), .hold(hold), .busy(busy),
    .powered(powered), .data_valid(data_valid));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse;
    sck = 1'b1; wait_n(6);
    sck = 1'b0; wait_n(6);
  endtask

  task automatic release_cs;
    csn = 1'b1; wait_n(6);
    chk("R5 enable off with cs high", sdo_oe, 0);
  endtask

  task automatic frame(input logic [11:0] v, input int n, input bit from_sleep);
    logic [15:0] f;
    f = {2'b00, v, 2'b00};
    smp = v;
    wait_n(2);
    csn = 1'b0; wait_n(6);
    smp = ~v;
    chk("R1 enable", sdo_oe, 1);
    chk("R1 first zero", sdo, 0);
    chk("R1 hold", hold, 1);
    chk("R1 busy", busy, 1);
    chk("R9 valid flag", data_valid, !from_sleep);
    for (int k = 1; k <= n; k++) begin
      pulse();
      if (k < 16) begin
        chk("R2 enable in frame", sdo_oe, 1);
        if (!from_sleep) chk("R2/R10 bit", sdo, (f >> (15 - k)) & 16'd1);
      end else begin
        chk("R5 enable off at 16", sdo_oe, 0);
      end
      if (k == 12) chk("R4 busy before 13", busy, 1);
      if (k == 13) chk("R4 busy at 13", busy, 0);
      if (from_sleep) begin
        if (k == 1)  chk("R9 hold after 1st", hold, 0);
        if (k == 15) chk("R9 asleep at 15", powered, 0);
        if (k == 16) chk("R9 powered at 16", powered, 1);
      end else begin
        if (k == 13) chk("R4 hold at 13", hold, 1);
        if (k == 14) chk("R4 hold at 14", hold, 0);
      end
    end
  endtask

  task automatic report;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
    end
  end

  initial begin
    wait_n(5);
    rst_n = 1'b1;
    wait_n(4);
    chk("R6 powered", powered, 0);
    chk("R6 enable", sdo_oe, 0);
    chk("R6 hold", hold, 1);
    chk("R6 busy", busy, 0);
    chk("R6 valid", data_valid, 0);

    frame(12'h5A5, 8, 1'b1);
    release_cs();
    chk("R9 short wake stays asleep", powered, 0);
    chk("R9 short wake hold", hold, 1);

    frame(12'h123, 16, 1'b1);
    release_cs();
    chk("R9 awake", powered, 1);

    for (int v = 0; v < 4096; v += 29) begin
      frame(12'(v), 16, 1'b0);
      release_cs();
    end
    for (int b = 0; b < 12; b++) begin
      frame(12'(1 << b), 16, 1'b0);
      release_cs();
    end
    frame(12'hAAA, 16, 1'b0); release_cs();
    frame(12'h555, 16, 1'b0); release_cs();
    frame(12'hFFF, 16, 1'b0);
    pulse(); pulse();
    chk("R5 extra edges ignored", sdo_oe, 0);
    chk("R5 extra edges power", powered, 1);
    release_cs();

    frame(12'h3C3, 12, 1'b0);
    release_cs();
    chk("R8 powered", powered, 1);
    chk("R8 busy", busy, 0);
    chk("R8 hold", hold, 0);
    frame(12'hC3C, 10, 1'b0);
    release_cs();
    chk("R8 boundary 10 powered", powered, 1);
    chk("R8 boundary 10 hold", hold, 0);

    frame(12'h0F0, 9, 1'b0);
    release_cs();
    chk("R7 boundary 9 sleep", powered, 0);
    chk("R7 boundary 9 hold", hold, 1);
    frame(12'h777, 16, 1'b1); release_cs();
    frame(12'h888, 2, 1'b0);
    release_cs();
    chk("R7 boundary 2 sleep", powered, 0);
    frame(12'h999, 16, 1'b1); release_cs();
    frame(12'h246, 5, 1'b0);
    release_cs();
    chk("R7 mid sleep", powered, 0);
    chk("R7 mid hold", hold, 1);
    frame(12'hABC, 3, 1'b1);
    release_cs();
    chk("R9 stays asleep", powered, 0);

    done = 1'b1;
    report();
    $finish;
  end
endmodule